// File: doc/BRIEF.md
# History-Banked Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short global record of how the most recent branches resolved. That record picks one of several banks of two-bit saturating counters. A few low bits of the branch address then pick the counter inside that bank. A branch that behaves differently depending on what the branches just before it did therefore trains a different counter in each of those contexts.

A fetch stage presents the branch address on the lookup port. In the same cycle it receives the predicted direction and the history value in use. It keeps that history value alongside the branch. When the branch resolves, the back end presents the address, the actual outcome and the saved history on the update port. The counter in the bank named by the saved history is trained. The outcome also shifts into the global history. Lookups are combinational from registered state, so a lookup in the same cycle as an update sees the state from before that update.

Top module: `hist_bank_bp`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the global history is 2'b00. A lookup at any address then predicts not taken and reports history 2'b00.
- R2: The prediction is the most significant bit of the selected counter. Counter values 2 and 3 predict taken (lk_pred = 1). Values 0 and 1 predict not taken (lk_pred = 0).
- R3: An update with up_taken = 1 raises the selected counter by one. At 3 it stays at 3.
- R4: An update with up_taken = 0 lowers the selected counter by one. At 0 it stays at 0.
- R5: An update changes only the counter at bank up_hist and entry up_pc[5:2]. Every other counter in every bank keeps its value.
- R6: Each update shifts the global history left by one bit, with up_taken entering bit 0. The value 2'b01 therefore means the older branch was not taken and the newer one was taken. lk_hist shows the current history.
- R7: A lookup reads the bank numbered by the current global history, at entry lk_pc[5:2]. Address bits outside [5:2] have no effect on the prediction.
- R8: When a lookup and an update fall in the same cycle, lk_pred and lk_hist reflect the state from before that update.
- R9: A counter at 3 still predicts taken after one not-taken update. It predicts not taken only after a second consecutive not-taken update.
- R10: While up_valid is 0, no counter and no history bit changes, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_pc | input | PC_W | Branch address being looked up |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Global history used for this lookup |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_hist | input | HIST_W | History value saved at lookup time |

## Verification
The predictor is driven with directed sequences and then with a long pseudo-random mix. Repeated training of one entry under a fixed saved history separates correct saturation at both ends from wrap-around. It also separates the two-miss hysteresis from a one-bit scheme. Updates whose saved history differs from the live global history, followed by lookups in other history contexts, show whether training leaks into a bank other than the named one. Address pairs that differ only outside the index field, same-cycle lookup-and-update at the same entry, and updates with the strobe low distinguish index aliasing, read-before-write ordering and spurious writes.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_INIT = ctr_t'(1);

  // Saturating step of a direction counter.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else       return (c == CTR_MIN) ? c : c - ctr_t'(1);
  endfunction

  // Predicted direction from a counter value.
  function automatic logic ctr_dir(input ctr_t c);
    return c[CTR_W-1];
  endfunction

endpackage

// File: rtl/hbp_ghist.sv
module hbp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (shift_i) hist_q <= HIST_W'({hist_q, bit_i});
  end

  assign hist_o = hist_q;

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (hist_o == HIST_W'({$past(hist_o), $past(bit_i)})));

  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(hist_o));

endmodule

// File: rtl/hbp_bank_dec.sv
module hbp_bank_dec #(
  parameter int HIST_W = 2,
  localparam int NBANK = 1 << HIST_W
) (
  input  logic              en_i,
  input  logic [HIST_W-1:0] sel_i,
  output logic [NBANK-1:0]  we_o
);

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign we_o[b] = en_i && (sel_i == HIST_W'(b));
  end

  always_comb begin
    assert_dec_onehot_R5: assert ($onehot0(we_o));
  end

endmodule

// File: rtl/hbp_ctr_bank.sv
module hbp_ctr_bank import hbp_pkg::*; #(
  parameter int IDX_W = 4,
  localparam int NENT = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wtaken_i,
  input  logic [IDX_W-1:0] ridx_i,
  output ctr_t             rctr_o
);

  ctr_t [NENT-1:0] ctr_q;

  // Named events for the checks below.
  ctr_t wr_cur;
  logic hit_top, hit_bot;
  assign wr_cur  = ctr_q[widx_i];
  assign hit_top = we_i && wtaken_i && (wr_cur == CTR_MAX);
  assign hit_bot = we_i && !wtaken_i && (wr_cur == CTR_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) ctr_q[e] <= CTR_INIT;
    end else if (we_i) begin
      ctr_q[widx_i] <= ctr_step(wr_cur, wtaken_i);
    end
  end

  assign rctr_o = ctr_q[ridx_i];

  assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_top |=> (ctr_q[$past(widx_i)] == CTR_MAX));

  assert_sat_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bot |=> (ctr_q[$past(widx_i)] == CTR_MIN));

  assert_taken_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wtaken_i && !hit_top) |=>
      (ctr_q[$past(widx_i)] == $past(wr_cur) + ctr_t'(1)));

  assert_not_taken_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wtaken_i && !hit_bot) |=>
      (ctr_q[$past(widx_i)] == $past(wr_cur) - ctr_t'(1)));

  assert_idle_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctr_q));

endmodule

// File: rtl/hist_bank_bp.sv
module hist_bank_bp import hbp_pkg::*; #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 2,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_pred,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);

  localparam int NBANK = 1 << HIST_W;

  function automatic logic [IDX_W-1:0] pc_to_idx(input logic [PC_W-1:0] pc);
    return pc[IDX_LSB +: IDX_W];
  endfunction

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [NBANK-1:0]  bank_we;
  ctr_t              rd_ctr [NBANK];
  ctr_t              lk_ctr;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc, up_pc};

  assign lk_idx = pc_to_idx(lk_pc);
  assign up_idx = pc_to_idx(up_pc);

  hbp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (up_valid),
    .bit_i   (up_taken),
    .hist_o  (ghist)
  );

  hbp_bank_dec #(.HIST_W(HIST_W)) u_dec (
    .en_i  (up_valid),
    .sel_i (up_hist),
    .we_o  (bank_we)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    hbp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (bank_we[b]),
      .widx_i   (up_idx),
      .wtaken_i (up_taken),
      .ridx_i   (lk_idx),
      .rctr_o   (rd_ctr[b])
    );
  end

  assign lk_ctr  = rd_ctr[ghist];
  assign lk_pred = ctr_dir(lk_ctr);
  assign lk_hist = ghist;

  assert_write_named_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (bank_we[up_hist] && $countones(bank_we) == 1));

  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |-> (bank_we == '0));

endmodule

// File: tb/hist_bank_bp_tb_top.sv
module hist_bank_bp_tb_top;

  localparam int PC_W = 32;
  localparam int NB   = 4;
  localparam int NE   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic            lk_pred, up_valid, up_taken;
  logic [1:0]      lk_hist, up_hist;

  hist_bank_bp dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist)
  );

  typedef struct {
    string      req;
    logic       pred;
    logic [1:0] hist;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Reference state.
  bit [1:0] m_ctr [NB][NE];
  bit [1:0] m_hist;
  bit [31:0] lfsr = 32'h1D2C_3B4A;

  function automatic bit [1:0] m_next(bit [1:0] c, bit t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic bit [3:0] m_idx(bit [31:0] pc);
    return pc[5:2];
  endfunction

  task automatic step(string req, bit [31:0] pc, bit uv, bit [31:0] upc, bit ut, bit [1:0] uh);
    exp_t e;
    @(negedge clk);
    lk_pc = pc; up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh;
    e.req  = req;
    e.pred = m_ctr[m_hist][m_idx(pc)][1];
    e.hist = m_hist;
    sbq.push_back(e);
    if (uv) begin
      m_ctr[uh][m_idx(upc)] = m_next(m_ctr[uh][m_idx(upc)], ut);
      m_hist = {m_hist[0], ut};
    end
  endtask

  task automatic look(string req, bit [31:0] pc);
    step(req, pc, 1'b0, 32'h0, 1'b0, 2'b00);
  endtask

  task automatic upd(string req, bit [31:0] pc, bit t, bit [1:0] h);
    step(req, pc, 1'b1, pc, t, h);
  endtask

  // Monitor: compare after the driver has settled the inputs.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (lk_pred !== e.pred) begin
          errors++;
          $display("FAIL %s pred actual %b expected %b", e.req, lk_pred, e.pred);
        end
        checks++;
        if (lk_hist !== e.hist) begin
          errors++;
          $display("FAIL %s hist actual %b expected %b", e.req, lk_hist, e.hist);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < NE; i++) m_ctr[b][i] = 2'd1;
    m_hist = 2'b00;
    rst_n = 1'b0; lk_pc = '0; up_pc = '0; up_valid = 1'b0; up_taken = 1'b0; up_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    look("R1", 32'h0000_0000);
    look("R1", 32'h0000_003C);
    look("R1", 32'hFFFF_FFFC);

    // R3 and R2: train bank 0 entry 12 to strong taken, saturating
    upd("R3", 32'h30, 1'b1, 2'b00);
    upd("R3", 32'h30, 1'b1, 2'b00);
    upd("R3", 32'h30, 1'b1, 2'b00);
    // drive history back to 00 via other entries
    upd("R6", 32'h04, 1'b0, 2'b11);
    upd("R6", 32'h04, 1'b0, 2'b10);
    look("R2", 32'h30);
    // R9: hysteresis
    upd("R9", 32'h30, 1'b0, 2'b00);
    look("R9", 32'h30);
    upd("R9", 32'h30, 1'b0, 2'b00);
    look("R9", 32'h30);
    // R4: saturate at 0
    upd("R4", 32'h30, 1'b0, 2'b00);
    upd("R4", 32'h30, 1'b0, 2'b00);
    upd("R4", 32'h30, 1'b0, 2'b00);
    upd("R4", 32'h30, 1'b1, 2'b00);
    upd("R4", 32'h08, 1'b0, 2'b01);
    upd("R4", 32'h08, 1'b0, 2'b10);
    look("R4", 32'h30);

    // R5: train bank 3 entry 8, then look in bank 0
    upd("R5", 32'h20, 1'b1, 2'b11);
    upd("R5", 32'h20, 1'b1, 2'b11);
    upd("R5", 32'h00, 1'b0, 2'b11);
    upd("R5", 32'h00, 1'b0, 2'b10);
    look("R5", 32'h20);
    upd("R5", 32'h0C, 1'b1, 2'b00);
    upd("R5", 32'h0C, 1'b1, 2'b01);
    look("R5", 32'h20);

    // R6: history order, 01 = older not taken, newer taken
    upd("R6", 32'h14, 1'b1, 2'b00);
    upd("R6", 32'h14, 1'b0, 2'b01);
    look("R6", 32'h14);
    upd("R6", 32'h18, 1'b1, 2'b10);
    look("R6", 32'h18);

    // R7: address bits outside [5:2] ignored
    look("R7", 32'h0000_0020);
    look("R7", 32'h8000_0060);
    look("R7", 32'h1234_5FE0);

    // R8: same-cycle lookup and update see old state
    step("R8", 32'h20, 1'b1, 32'h20, 1'b0, 2'b01);
    step("R8", 32'h20, 1'b1, 32'h20, 1'b1, 2'b11);
    look("R8", 32'h20);

    // R10: strobe low ignores update inputs
    step("R10", 32'h24, 1'b0, 32'h24, 1'b1, 2'b10);
    step("R10", 32'h24, 1'b0, 32'h24, 1'b1, 2'b10);
    look("R10", 32'h24);

    // Mixed traffic
    for (int n = 0; n < 600; n++) begin
      bit [31:0] pc;
      bit [1:0]  h;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pc = {lfsr[31:8], lfsr[5:2], 2'b00};
      h  = lfsr[6] ? m_hist : lfsr[13:12];
      step("R5 R7", pc, lfsr[7] | lfsr[9], pc ^ {lfsr[15:14], 4'b0}, lfsr[10], h);
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule